// File: doc/BRIEF.md
# Threshold FIFO with DMA request

This block holds the two sample buffers of an audio serial port. The transmit buffer is filled by the system bus and drained by the serial shifter. The receive buffer is filled by the serial shifter and drained by the bus. Each buffer drives a DMA request line. In element mode the line asks for service as soon as one word can move. In threshold mode it waits until enough room (transmit) or enough data (receive) has built up, so the DMA engine can move the data in bursts.

A small register port sets the per-direction thresholds, the upper limit each threshold may take, and the request mode. It also reads back the buffer levels. Threshold values are written one-based and kept as the value minus one. A write outside the allowed range is ignored. The transmit status register gives the number of free locations. The receive status register gives the number of occupied locations. Overflow (a push into a full buffer) and underflow (a pop from an empty buffer) are flagged separately for each direction. All push and pop interfaces are single-cycle strobes with no handshake. Both sides run on one clock.

Top module: `sport_fifo_dma`

## Requirements
- R1: Writing a threshold value N in the range 1..limit to register 0 (transmit) or register 1 (receive) stores N-1, and reading that register returns N-1. Both registers reset to 0.
- R2: A threshold write of 0, or of any value above the current limit of that direction, leaves the threshold register unchanged.
- R3: The limit registers (5 for transmit, 6 for receive) reset to DEPTH-16. A write of 1..DEPTH replaces the limit. A write of 0 or above DEPTH is ignored.
- R4: Register 2 reads the number of free transmit locations, DEPTH minus the words held.
- R5: Register 3 reads the number of words held in the receive buffer.
- R6: With bit 0 of mode register 4 set (transmit threshold mode), tx_dma_req is high exactly when free locations are at least the stored transmit threshold plus one.
- R7: With bit 1 of mode register 4 set (receive threshold mode), rx_dma_req is high exactly when held words are at least the stored receive threshold plus one.
- R8: With a mode bit clear (element mode, the reset state), tx_dma_req is high whenever at least one location is free, and rx_dma_req is high whenever at least one word is held.
- R9: Each buffer returns words in the order they were pushed, and pop data is valid in the same cycle as the pop strobe.
- R10: A push into a full buffer is dropped, the level does not change, and that direction's overflow output is high for exactly the one cycle after the push edge.
- R11: A pop from an empty buffer returns zero, and that direction's underflow output is high for exactly the one cycle after the pop edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | CFGW | Register write value |
| cfg_rdata | output | CFGW | Register read value, combinational from cfg_addr |
| tx_push | input | 1 | Bus writes one transmit word |
| tx_push_data | input | DW | Transmit word from the bus |
| tx_pop | input | 1 | Serial side takes one transmit word |
| tx_pop_data | output | DW | Head transmit word, zero when empty |
| tx_dma_req | output | 1 | Transmit service request |
| tx_ovf | output | 1 | Transmit overflow pulse |
| tx_udf | output | 1 | Transmit underflow pulse |
| rx_push | input | 1 | Serial side delivers one receive word |
| rx_push_data | input | DW | Received word |
| rx_pop | input | 1 | Bus reads one receive word |
| rx_pop_data | output | DW | Head receive word, zero when empty |
| rx_dma_req | output | 1 | Receive service request |
| rx_ovf | output | 1 | Receive overflow pulse |
| rx_udf | output | 1 | Receive underflow pulse |

## Verification
Register reads and pop data are combinational, so the bench samples them shortly after it sets the address or the pop strobe, within the same cycle. Levels, status reads, request lines and the overflow and underflow pulses all change at the first clock edge after a push, pop or register write. The bench drives every strobe on a falling edge, drops it on the next falling edge, and samples these results there, one edge later. A monitor compares each popped word against the scoreboard queue two nanoseconds after the falling edge that raised the strobe. It expects zero whenever the model queue is empty.

// File: rtl/sport_fifo_pkg.sv
package sport_fifo_pkg;
    typedef enum logic [2:0] {
        REG_TX_THR  = 3'd0,
        REG_RX_THR  = 3'd1,
        REG_TX_FREE = 3'd2,
        REG_RX_USED = 3'd3,
        REG_MODE    = 3'd4,
        REG_TX_MAX  = 3'd5,
        REG_RX_MAX  = 3'd6
    } cfg_reg_e;

    // headroom kept below the buffer depth by the default limit
    localparam int SAFETY_MARGIN = 16;
endpackage

// File: rtl/sport_fifo_lane.sv
module sport_fifo_lane #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] used,
    output logic          ovf,
    output logic          udf
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          udf;
    } lane_t;

    lane_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic full, empty, do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        st_d.ovf = push && full;
        st_d.udf = pop && empty;
        if (do_push) st_d.wptr = bump(st_q.wptr);
        if (do_pop)  st_d.rptr = bump(st_q.rptr);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= push_data;
    end

    assign pop_data = empty ? '0 : mem[st_q.rptr];
    assign used     = st_q.cnt;
    assign ovf      = st_q.ovf;
    assign udf      = st_q.udf;
endmodule

// File: rtl/sport_thr_regs.sv
module sport_thr_regs
    import sport_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CFGW  = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [CFGW-1:0] cfg_wdata,
    output logic [CFGW-1:0] cfg_rdata,
    input  logic [CW-1:0]   tx_free,
    input  logic [CW-1:0]   rx_used,
    output logic [TW-1:0]   tx_thr,
    output logic [TW-1:0]   rx_thr,
    output logic            tx_thr_mode,
    output logic            rx_thr_mode
);
    typedef struct packed {
        logic [TW-1:0] tx_thr;
        logic [TW-1:0] rx_thr;
        logic [CW-1:0] tx_max;
        logic [CW-1:0] rx_max;
        logic          tx_mode;
        logic          rx_mode;
    } regs_t;

    regs_t st_d, st_q;
    logic  tx_thr_ok, rx_thr_ok, max_ok;

    assign tx_thr_ok = (cfg_wdata != '0) && (cfg_wdata <= CFGW'(st_q.tx_max));
    assign rx_thr_ok = (cfg_wdata != '0) && (cfg_wdata <= CFGW'(st_q.rx_max));
    assign max_ok    = (cfg_wdata != '0) && (cfg_wdata <= CFGW'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_reg_e'(cfg_addr))
                REG_TX_THR: if (tx_thr_ok) st_d.tx_thr = TW'(cfg_wdata - 1'b1);
                REG_RX_THR: if (rx_thr_ok) st_d.rx_thr = TW'(cfg_wdata - 1'b1);
                REG_TX_MAX: if (max_ok)    st_d.tx_max = CW'(cfg_wdata);
                REG_RX_MAX: if (max_ok)    st_d.rx_max = CW'(cfg_wdata);
                REG_MODE: begin
                    st_d.tx_mode = cfg_wdata[0];
                    st_d.rx_mode = cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.tx_max  <= CW'(DEPTH - SAFETY_MARGIN);
            st_q.rx_max  <= CW'(DEPTH - SAFETY_MARGIN);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cfg_reg_e'(cfg_addr))
            REG_TX_THR:  cfg_rdata = CFGW'(st_q.tx_thr);
            REG_RX_THR:  cfg_rdata = CFGW'(st_q.rx_thr);
            REG_TX_FREE: cfg_rdata = CFGW'(tx_free);
            REG_RX_USED: cfg_rdata = CFGW'(rx_used);
            REG_MODE:    cfg_rdata = CFGW'({st_q.rx_mode, st_q.tx_mode});
            REG_TX_MAX:  cfg_rdata = CFGW'(st_q.tx_max);
            REG_RX_MAX:  cfg_rdata = CFGW'(st_q.rx_max);
            default:     cfg_rdata = '0;
        endcase
    end

    assign tx_thr      = st_q.tx_thr;
    assign rx_thr      = st_q.rx_thr;
    assign tx_thr_mode = st_q.tx_mode;
    assign rx_thr_mode = st_q.rx_mode;
endmodule

// File: rtl/sport_dma_req.sv
module sport_dma_req #(
    parameter int CW = 8,
    parameter int TW = 7
) (
    input  logic [CW-1:0] level,
    input  logic [TW-1:0] thr,
    input  logic          thr_mode,
    output logic          req
);
    // level >= thr + 1 is the same as level > thr and needs no adder
    assign req = thr_mode ? (level > CW'(thr)) : (level != '0);
endmodule

// File: rtl/sport_fifo_dma.sv
module sport_fifo_dma #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    parameter int CFGW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [CFGW-1:0] cfg_wdata,
    output logic [CFGW-1:0] cfg_rdata,
    input  logic            tx_push,
    input  logic [DW-1:0]   tx_push_data,
    input  logic            tx_pop,
    output logic [DW-1:0]   tx_pop_data,
    output logic            tx_dma_req,
    output logic            tx_ovf,
    output logic            tx_udf,
    input  logic            rx_push,
    input  logic [DW-1:0]   rx_push_data,
    input  logic            rx_pop,
    output logic [DW-1:0]   rx_pop_data,
    output logic            rx_dma_req,
    output logic            rx_ovf,
    output logic            rx_udf
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] tx_used, tx_free, rx_used;
    logic [TW-1:0] tx_thr, rx_thr;
    logic          tx_thr_mode, rx_thr_mode;

    sport_fifo_lane #(.DEPTH(DEPTH), .DW(DW)) u_tx_lane (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(tx_push_data),
        .pop(tx_pop), .pop_data(tx_pop_data),
        .used(tx_used), .ovf(tx_ovf), .udf(tx_udf)
    );

    sport_fifo_lane #(.DEPTH(DEPTH), .DW(DW)) u_rx_lane (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_pop), .pop_data(rx_pop_data),
        .used(rx_used), .ovf(rx_ovf), .udf(rx_udf)
    );

    assign tx_free = CW'(DEPTH) - tx_used;

    sport_thr_regs #(.DEPTH(DEPTH), .CFGW(CFGW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_free(tx_free), .rx_used(rx_used),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_thr_mode(tx_thr_mode), .rx_thr_mode(rx_thr_mode)
    );

    sport_dma_req #(.CW(CW), .TW(TW)) u_tx_req (
        .level(tx_free), .thr(tx_thr), .thr_mode(tx_thr_mode), .req(tx_dma_req)
    );

    sport_dma_req #(.CW(CW), .TW(TW)) u_rx_req (
        .level(rx_used), .thr(rx_thr), .thr_mode(rx_thr_mode), .req(rx_dma_req)
    );
endmodule

// File: rtl/sport_fifo_dma_chk.sv
module sport_fifo_dma_chk #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    parameter int CW    = 8,
    parameter int TW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          rx_pop,
    input logic [CW-1:0] tx_free,
    input logic [CW-1:0] rx_used,
    input logic [TW-1:0] tx_thr,
    input logic          tx_ovf,
    input logic          rx_udf,
    input logic [DW-1:0] rx_pop_data,
    input logic          rx_dma_req
);
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(tx_thr)); // R2
    AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_free <= CW'(DEPTH)); // R4
    AST_RX_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_used == '0) |-> !rx_dma_req); // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |-> ($past(tx_push) && ($past(tx_free) == '0))); // R10
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && (tx_free == '0) && !tx_pop) |=> (tx_free == '0)); // R10
    AST_UDF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && (rx_used == '0)) |-> (rx_pop_data == '0)); // R11
    AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_udf |-> ($past(rx_pop) && ($past(rx_used) == '0))); // R11
endmodule

bind sport_fifo_dma sport_fifo_dma_chk #(
    .DEPTH(DEPTH), .DW(DW), .CW(CW), .TW(TW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_pop(rx_pop),
    .tx_free(tx_free), .rx_used(rx_used), .tx_thr(tx_thr),
    .tx_ovf(tx_ovf), .rx_udf(rx_udf), .rx_pop_data(rx_pop_data),
    .rx_dma_req(rx_dma_req)
);

// File: tb/sport_fifo_dma_tb.sv
`timescale 1ns/1ps
module sport_fifo_dma_tb;
    localparam int DEPTH = 128;
    localparam int DW    = 32;
    localparam int CFGW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [CFGW-1:0] cfg_wdata = '0;
    logic [CFGW-1:0] cfg_rdata;
    logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [DW-1:0] tx_push_data = '0, rx_push_data = '0;
    logic [DW-1:0] tx_pop_data, rx_pop_data;
    logic tx_dma_req, tx_ovf, tx_udf, rx_dma_req, rx_ovf, rx_udf;

    always #2.5 clk = ~clk;

    sport_fifo_dma #(.DEPTH(DEPTH), .DW(DW), .CFGW(CFGW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_dma_req(tx_dma_req), .tx_ovf(tx_ovf), .tx_udf(tx_udf),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_dma_req(rx_dma_req), .rx_ovf(rx_ovf), .rx_udf(rx_udf)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CFGW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [CFGW-1:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic push_tx(input logic [DW-1:0] d);
        @(negedge clk);
        tx_push = 1'b1; tx_push_data = d;
        if (txq.size() < DEPTH) txq.push_back(d);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input logic [DW-1:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_push_data = d;
        if (rxq.size() < DEPTH) rxq.push_back(d);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    // scoreboard monitors: R9 order, R11 zero on empty
    always @(negedge clk) begin
        #2;
        if (tx_pop) chk("R9 tx order", tx_pop_data, (txq.size() != 0) ? txq.pop_front() : '0);
        if (rx_pop) chk((rxq.size() != 0) ? "R9 rx order" : "R11 rx empty data",
                        rx_pop_data, (rxq.size() != 0) ? rxq.pop_front() : '0);
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [CFGW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(3'd2, v); chk("R4 reset free", v, DEPTH);
        rd(3'd3, v); chk("R5 reset used", v, 0);
        rd(3'd0, v); chk("R1 reset thr", v, 0);
        rd(3'd5, v); chk("R3 default tx limit", v, DEPTH - 16);
        rd(3'd6, v); chk("R3 default rx limit", v, DEPTH - 16);
        chk("R8 reset tx req", tx_dma_req, 1);
        chk("R8 reset rx req", rx_dma_req, 0);

        wr(3'd0, 16'd32); rd(3'd0, v); chk("R1 tx thr minus one", v, 31);
        wr(3'd0, 16'd0);  rd(3'd0, v); chk("R2 zero rejected", v, 31);
        wr(3'd0, 16'd113); rd(3'd0, v); chk("R2 above limit rejected", v, 31);
        wr(3'd0, 16'd112); rd(3'd0, v); chk("R1 at limit accepted", v, 111);
        wr(3'd1, 16'd4);  rd(3'd1, v); chk("R1 rx thr minus one", v, 3);

        wr(3'd5, 16'd129); rd(3'd5, v); chk("R3 limit above depth ignored", v, 112);
        wr(3'd5, 16'd120); rd(3'd5, v); chk("R3 limit written", v, 120);
        wr(3'd0, 16'd120); rd(3'd0, v); chk("R3 raised limit allows thr", v, 119);
        wr(3'd5, 16'd112);
        wr(3'd0, 16'd32);  rd(3'd0, v); chk("R1 tx thr restored", v, 31);

        wr(3'd4, 16'd3);
        chk("R6 empty tx req", tx_dma_req, 1);
        for (int i = 0; i < 96; i++) push_tx(32'hA500_0000 + i);
        chk("R6 free 32 req", tx_dma_req, 1);
        push_tx(32'hA500_0060);
        chk("R6 free 31 no req", tx_dma_req, 0);
        rd(3'd2, v); chk("R4 free after 97", v, 31);
        for (int i = 0; i < 97; i++) pop_tx();
        rd(3'd2, v); chk("R4 free after drain", v, DEPTH);

        for (int i = 0; i < 3; i++) push_rx(32'h5C00_0000 + i * 7);
        chk("R7 used 3 no req", rx_dma_req, 0);
        rd(3'd3, v); chk("R5 used 3", v, 3);
        push_rx(32'h5C00_00FF);
        chk("R7 used 4 req", rx_dma_req, 1);
        for (int i = 0; i < 4; i++) pop_rx();

        wr(3'd4, 16'd0);
        push_rx(32'h1234_5678);
        chk("R8 rx one word req", rx_dma_req, 1);
        pop_rx();
        chk("R8 rx empty no req", rx_dma_req, 0);
        for (int i = 0; i < DEPTH; i++) push_tx(32'h0F00_0000 ^ (i * 32'h0101));
        chk("R8 tx full no req", tx_dma_req, 0);
        chk("R10 no ovf before full push", tx_ovf, 0);
        push_tx(32'hDEAD_BEEF);
        chk("R10 tx ovf pulse", tx_ovf, 1);
        chk("R10 rx ovf separate", rx_ovf, 0);
        rd(3'd2, v); chk("R10 free stays 0", v, 0);
        chk("R10 ovf one cycle", tx_ovf, 0);
        for (int i = 0; i < DEPTH; i++) pop_tx();
        chk("R9 tx queue drained", txq.size(), 0);

        pop_rx();
        chk("R11 rx udf pulse", rx_udf, 1);
        chk("R11 tx udf separate", tx_udf, 0);
        rd(3'd3, v); chk("R11 used stays 0", v, 0);
        chk("R11 udf one cycle", rx_udf, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule